// File: doc/BRIEF.md
# Dual Gated Timer/Counter Unit

This block holds two independent up-counting channels, each sixteen bits wide and split into a high byte and a low byte. Either byte can be loaded by software. Each channel advances on the internal tick or on falling edges of its own external count pin. The external pin is asynchronous, so it is first passed through a synchronizer. Counting needs the channel's run bit. When the channel's gate option is on, counting also needs the channel's external gate pin to be high.

Each channel takes its settings from one nibble of a configuration byte. That byte can only be written whole. The nibble holds the gate option, the count source and a two-bit mode. The modes are: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself, and a split mode. Run bits and overflow flags are written one bit at a time. An overflow flag goes up when its counter wraps, and it drops again when the matching interrupt acknowledge is pulsed.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, both counts, both run bits, both overflow flags and the configuration byte are zero.
- R2: A configuration write loads all eight bits in the cycle after `cfg_we`. Bits [3:0] configure channel 0 and bits [7:4] configure channel 1. Within a nibble, bit 3 is the gate option, bit 2 selects the external source (1) or the tick (0), and bits [1:0] are the mode: 00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split. Without `cfg_we` the byte holds.
- R3: A bit write changes exactly one control bit. The bit is chosen by `bit_sel`: 0 = run of channel 0, 1 = run of channel 1, 2 = flag of channel 0, 3 = flag of channel 1.
- R4: A channel counts only while its run bit is 1 and either its gate option is 0 or its `ext_gate` pin is 1. Otherwise its count holds.
- R5: Mode 01 counts through all sixteen bits. A step from FFFFh gives 0000h and sets the channel's flag.
- R6: Mode 00 counts a 13-bit value made of the high byte (upper part) and the low 5 bits of the low byte. Bits [7:5] of the low byte do not change. A step from the all-ones value wraps to zero and sets the flag.
- R7: Mode 10 increments the low byte only. A step from FFh loads the low byte from the high byte and sets the flag.
- R8: Mode 11 on channel 0 splits it into two 8-bit counters:
  - The low byte counts under channel 0's controls and sets flag 0 when it wraps.
  - The high byte counts ticks while run bit 1 is set, and sets flag 1 when it wraps.
  - Channel 1 keeps counting under its own settings, but its wraps no longer set flag 1.
  - Channel 1 in mode 11 holds its count.
- R9: A channel steps only in cycles where `tick` is 1. With source 0 it steps once per tick cycle. With source 1 it counts falling edges of `ext_cnt`:
  - The pin passes through a two-stage synchronizer, and an edge is counted at the third rising clock edge after the pin falls (if `tick` is high then).
  - An edge that arrives while `tick` is low is held until the next tick cycle.
  - A channel takes at most one step per tick cycle, however many edges were held.
- R10: A byte write to a channel takes priority over that channel's increment in the same cycle. The written byte takes the new data, the other byte holds, and no flag is set from that channel.
- R11: Pulsing `irq_ack[i]` clears flag i in the next cycle. An overflow in the same cycle leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Internal count tick |
| ext_cnt | input | 2 | Asynchronous external count pins, one per channel |
| ext_gate | input | 2 | Gate pins, one per channel |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte |
| bit_we | input | 1 | Single control bit write strobe |
| bit_sel | input | 2 | Control bit select |
| bit_val | input | 1 | Value written to the selected bit |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_ch | input | 1 | Channel of the count byte write |
| cnt_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| cnt_wdata | input | BYTE_W | Count byte data |
| irq_ack | input | 2 | Interrupt acknowledge per channel |
| count0 | output | 2*BYTE_W | Channel 0 count |
| count1 | output | 2*BYTE_W | Channel 1 count |
| run | output | 2 | Run bits |
| ovf | output | 2 | Overflow flags |
| cfg | output | 8 | Configuration byte |

## Verification
Results are due on different cycles:
- Every timer step, configuration write, bit write, byte write and acknowledge is visible one clock edge after the cycle that carries it. The bench therefore drives all inputs on the falling edge and reads the outputs on the next falling edge.
- An external count edge appears three rising edges after the pin falls. The bench checks that the count is unchanged after two edges and one higher after the third.
- For the timer modes, a chosen number of tick cycles is applied. The expected count and flag are then computed by stepping an arithmetic model of the mode the same number of times.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

    localparam int NUM_CH = 2;
    localparam int CFG_NIB = 4;
    localparam int CFG_W = NUM_CH * CFG_NIB;

    typedef enum logic [1:0] {
        MODE_13    = 2'b00,
        MODE_16    = 2'b01,
        MODE_8R    = 2'b10,
        MODE_SPLIT = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext_src;
        tmode_e mode;
    } chan_cfg_t;

endpackage

// File: rtl/dual_timer_edge.sv
module dual_timer_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic tick,
    output logic evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              pend_q;
    logic              pend_d;
    logic              fall;

    always_comb begin
        fall   = prev_q & ~sync_q[STAGES-1];
        evt    = tick & (pend_q | fall);
        pend_d = (pend_q | fall) & ~tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/dual_timer_core.sv
module dual_timer_core
    import dual_timer_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRE_W    = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  tmode_e            mode,
    input  logic              step,
    input  logic              hstep,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi_n,
    output logic [BYTE_W-1:0] lo_n,
    output logic              wrap,
    output logic              hwrap
);
    localparam int SHORT_W = BYTE_W + PRE_W;
    localparam int FULL_W  = 2 * BYTE_W;

    logic [SHORT_W-1:0] short_inc;
    logic [FULL_W-1:0]  full_inc;
    logic [BYTE_W-1:0]  lo_inc;
    logic [BYTE_W-1:0]  hi_inc;
    logic               split_en;

    assign short_inc = {hi, lo[PRE_W-1:0]} + 1'b1;
    assign full_inc  = {hi, lo} + 1'b1;
    assign lo_inc    = lo + 1'b1;
    assign hi_inc    = hi + 1'b1;

    generate
        if (SPLIT_OK) begin : g_split
            assign split_en = 1'b1;
        end else begin : g_hold
            assign split_en = 1'b0;
        end
    endgenerate

    always_comb begin
        hi_n  = hi;
        lo_n  = lo;
        wrap  = 1'b0;
        hwrap = 1'b0;
        case (mode)
            MODE_13: if (step) begin
                hi_n = short_inc[SHORT_W-1:PRE_W];
                lo_n = {lo[BYTE_W-1:PRE_W], short_inc[PRE_W-1:0]};
                wrap = &{hi, lo[PRE_W-1:0]};
            end
            MODE_16: if (step) begin
                {hi_n, lo_n} = full_inc;
                wrap = &{hi, lo};
            end
            MODE_8R: if (step) begin
                lo_n = (&lo) ? hi : lo_inc;
                wrap = &lo;
            end
            default: if (split_en) begin
                if (step) begin
                    lo_n = lo_inc;
                    wrap = &lo;
                end
                if (hstep) begin
                    hi_n  = hi_inc;
                    hwrap = &hi;
                end
            end
        endcase
    end
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
    import dual_timer_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRE_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          ext_cnt,
    input  logic [1:0]          ext_gate,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                bit_we,
    input  logic [1:0]          bit_sel,
    input  logic                bit_val,
    input  logic                cnt_we,
    input  logic                cnt_ch,
    input  logic                cnt_hi,
    input  logic [BYTE_W-1:0]   cnt_wdata,
    input  logic [1:0]          irq_ack,
    output logic [2*BYTE_W-1:0] count0,
    output logic [2*BYTE_W-1:0] count1,
    output logic [1:0]          run,
    output logic [1:0]          ovf,
    output logic [CFG_W-1:0]    cfg
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0] cnt;
        logic [NUM_CH-1:0]            run;
        logic [NUM_CH-1:0]            ovf;
        chan_cfg_t [NUM_CH-1:0]       cfg;
    } state_t;

    state_t s_q, s_d;

    logic [NUM_CH-1:0]             evt, step, hstep, wrap, hwrap;
    logic [NUM_CH-1:0][BYTE_W-1:0] hi_n, lo_n;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            chan_cfg_t c;
            assign c = s_q.cfg[g];

            dual_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (ext_cnt[g]),
                .tick (tick),
                .evt  (evt[g])
            );

            assign step[g]  = s_q.run[g] & (~c.gate | ext_gate[g])
                            & (c.ext_src ? evt[g] : tick);
            assign hstep[g] = (g == 0) ? (s_q.run[1] & tick) : 1'b0;

            dual_timer_core #(
                .BYTE_W  (BYTE_W),
                .PRE_W   (PRE_W),
                .SPLIT_OK(g == 0)
            ) u_core (
                .mode (c.mode),
                .step (step[g]),
                .hstep(hstep[g]),
                .hi   (s_q.cnt[g][CNT_W-1:BYTE_W]),
                .lo   (s_q.cnt[g][BYTE_W-1:0]),
                .hi_n (hi_n[g]),
                .lo_n (lo_n[g]),
                .wrap (wrap[g]),
                .hwrap(hwrap[g])
            );
        end
    endgenerate

    always_comb begin
        logic [NUM_CH-1:0] wr_hit;
        logic [NUM_CH-1:0] set_ovf;
        s_d = s_q;
        if (cfg_we) begin
            s_d.cfg = cfg_wdata;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            wr_hit[i] = cnt_we && (cnt_ch == 1'(i));
            if (wr_hit[i]) begin
                if (cnt_hi) s_d.cnt[i][CNT_W-1:BYTE_W] = cnt_wdata;
                else        s_d.cnt[i][BYTE_W-1:0]     = cnt_wdata;
            end else begin
                s_d.cnt[i] = {hi_n[i], lo_n[i]};
            end
        end
        set_ovf[0] = wrap[0] & ~wr_hit[0];
        set_ovf[1] = (s_q.cfg[0].mode == MODE_SPLIT) ? (hwrap[0] & ~wr_hit[0])
                                                      : (wrap[1] & ~wr_hit[1]);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bit_we && bit_sel == 2'(i)) s_d.run[i] = bit_val;
            if (irq_ack[i]) s_d.ovf[i] = 1'b0;
            if (bit_we && bit_sel == 2'(i + NUM_CH)) s_d.ovf[i] = bit_val;
            if (set_ovf[i]) s_d.ovf[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count0 = s_q.cnt[0];
    assign count1 = s_q.cnt[1];
    assign run    = s_q.run;
    assign ovf    = s_q.ovf;
    assign cfg    = s_q.cfg;
endmodule

// File: rtl/dual_timer_unit_chk.sv
module dual_timer_unit_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                cfg_we,
    input logic [7:0]          cfg_wdata,
    input logic                bit_we,
    input logic [1:0]          bit_sel,
    input logic                bit_val,
    input logic                cnt_we,
    input logic                cnt_ch,
    input logic                cnt_hi,
    input logic [BYTE_W-1:0]   cnt_wdata,
    input logic [1:0]          irq_ack,
    input logic [2*BYTE_W-1:0] count0,
    input logic [2*BYTE_W-1:0] count1,
    input logic [1:0]          run,
    input logic [1:0]          ovf,
    input logic [7:0]          cfg
);
    // R2
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg == $past(cfg_wdata));
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg));
    // R3
    a_r3_run0_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && bit_sel == 2'd0) |=> run[0] == $past(bit_val));
    a_r3_run1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_we && bit_sel == 2'd1) |=> $stable(run[1]));
    // R4
    a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !(cnt_we && !cnt_ch) && cfg[1:0] != 2'b11) |=> $stable(count0));
    // R9
    a_r9_no_step_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> ($stable(count0) && $stable(count1)));
    // R10
    a_r10_low_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !cnt_ch && !cnt_hi) |=> count0[BYTE_W-1:0] == $past(cnt_wdata));
    // R11
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[0] && !tick && !bit_we) |=> !ovf[0]);
endmodule

bind dual_timer_unit dual_timer_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val), .cnt_we(cnt_we),
    .cnt_ch(cnt_ch), .cnt_hi(cnt_hi), .cnt_wdata(cnt_wdata), .irq_ack(irq_ack),
    .count0(count0), .count1(count1), .run(run), .ovf(ovf), .cfg(cfg)
);

// File: tb/dual_timer_unit_bench.sv
module dual_timer_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  ext_cnt = 2'b11;
    logic [1:0]  ext_gate = 2'b00;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        bit_we = 1'b0;
    logic [1:0]  bit_sel = '0;
    logic        bit_val = 1'b0;
    logic        cnt_we = 1'b0;
    logic        cnt_ch = 1'b0;
    logic        cnt_hi = 1'b0;
    logic [7:0]  cnt_wdata = '0;
    logic [1:0]  irq_ack = '0;
    logic [15:0] count0, count1;
    logic [1:0]  run, ovf;
    logic [7:0]  cfg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_timer_unit u_dual_timer_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_cnt(ext_cnt), .ext_gate(ext_gate),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .bit_we(bit_we), .bit_sel(bit_sel),
        .bit_val(bit_val), .cnt_we(cnt_we), .cnt_ch(cnt_ch), .cnt_hi(cnt_hi),
        .cnt_wdata(cnt_wdata), .irq_ack(irq_ack), .count0(count0), .count1(count1),
        .run(run), .ovf(ovf), .cfg(cfg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wr_bit(input logic [1:0] s, input logic v);
        @(negedge clk); bit_we = 1'b1; bit_sel = s; bit_val = v;
        @(negedge clk); bit_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic ch, input logic hi, input logic [7:0] d);
        @(negedge clk); cnt_we = 1'b1; cnt_ch = ch; cnt_hi = hi; cnt_wdata = d;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic load(input logic ch, input logic [15:0] v);
        wr_cnt(ch, 1'b1, v[15:8]);
        wr_cnt(ch, 1'b0, v[7:0]);
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_ext(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ext_cnt[0] = 1'b0;
            repeat (3) @(negedge clk);
            ext_cnt[0] = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    // {wrap, next} for one step of modes 00, 01, 10
    function automatic logic [16:0] model_step(input logic [1:0] m, input logic [15:0] v);
        logic [12:0] p;
        case (m)
            2'b00: begin
                p = {v[15:8], v[4:0]};
                return {&p, p[12:5] + 8'(p[4:0] == 5'h1f), v[7:5], p[4:0] + 5'd1};
            end
            2'b01: return {&v, v + 16'd1};
            default: return (&v[7:0]) ? {1'b1, v[15:8], v[15:8]}
                                      : {1'b0, v[15:8], v[7:0] + 8'd1};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, pre;
        logic [16:0] r;
        logic        exp_f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset counts", {count0, count1}, 32'h0);
        check("R1 reset ctl", {run, ovf, cfg}, 12'h0);

        // R2 whole byte
        wr_cfg(8'hA5);
        check("R2 cfg load", cfg, 8'hA5);
        @(negedge clk);
        check("R2 cfg hold", cfg, 8'hA5);

        // R3 single bit writes
        wr_cfg(8'h00);
        wr_bit(2'd3, 1'b1);
        check("R3 ovf1 set alone", {run, ovf}, 4'b0010);
        wr_bit(2'd1, 1'b1);
        check("R3 run1 set alone", {run, ovf}, 4'b1010);
        wr_bit(2'd3, 1'b0);
        wr_bit(2'd1, 1'b0);
        check("R3 bits cleared", {run, ovf}, 4'b0000);

        // R5 R6 R7 mode sweep
        for (int ch = 0; ch < 2; ch++) begin
            for (int m = 0; m < 3; m++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    case (pi)
                        0: pre = 16'hFFFD;
                        1: pre = 16'hFFFE;
                        2: pre = 16'h00FE;
                        default: pre = 16'h12F0;
                    endcase
                    wr_cfg(8'(m << (4 * ch)));
                    wr_bit(2'(2 + ch), 1'b0);
                    load(1'(ch), pre);
                    wr_bit(2'(ch), 1'b1);
                    ticks(4);
                    wr_bit(2'(ch), 1'b0);
                    v = pre; exp_f = 1'b0;
                    for (int s = 0; s < 4; s++) begin
                        r = model_step(2'(m), v);
                        v = r[15:0];
                        exp_f = exp_f | r[16];
                    end
                    check(m == 0 ? "R6 count" : (m == 1 ? "R5 count" : "R7 count"),
                          ch == 0 ? count0 : count1, v);
                    check(m == 0 ? "R6 flag" : (m == 1 ? "R5 flag" : "R7 flag"),
                          ovf[ch], exp_f);
                end
            end
        end

        // R8 split mode
        wr_cfg(8'h13);
        wr_bit(2'd2, 1'b0); wr_bit(2'd3, 1'b0);
        load(1'b0, 16'hFFFE); load(1'b1, 16'h0000);
        wr_bit(2'd0, 1'b1); wr_bit(2'd1, 1'b1);
        ticks(2);
        check("R8 split count0", count0, 16'h0100);
        check("R8 split count1 runs", count1, 16'h0002);
        check("R8 split flags", ovf, 2'b11);
        wr_bit(2'd2, 1'b0); wr_bit(2'd3, 1'b0);
        load(1'b0, 16'h0000); load(1'b1, 16'hFFFF);
        ticks(2);
        check("R8 split count0 b", count0, 16'h0202);
        check("R8 split count1 wraps", count1, 16'h0001);
        check("R8 ch1 wrap no flag", ovf, 2'b00);
        wr_cfg(8'h31);
        wr_bit(2'd0, 1'b0);
        load(1'b1, 16'h1234);
        ticks(3);
        check("R8 ch1 mode 11 holds", count1, 16'h1234);
        wr_bit(2'd1, 1'b0);

        // R4 gate and run
        wr_cfg(8'h09);
        load(1'b0, 16'h0000);
        wr_bit(2'd0, 1'b1);
        ext_gate[0] = 1'b0;
        ticks(5);
        check("R4 gate pin low holds", count0, 16'h0000);
        ext_gate[0] = 1'b1;
        ticks(5);
        check("R4 gate pin high counts", count0, 16'h0005);
        wr_bit(2'd0, 1'b0);
        ticks(4);
        check("R4 run off holds", count0, 16'h0005);

        // R9 external source
        wr_cfg(8'h05);
        load(1'b0, 16'h0000);
        wr_bit(2'd0, 1'b1);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); ext_cnt[0] = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 edge not yet", count0, 16'h0000);
        @(negedge clk);
        check("R9 edge third clock", count0, 16'h0001);
        ext_cnt[0] = 1'b1;
        repeat (2) @(negedge clk);
        pulse_ext(4);
        repeat (5) @(negedge clk);
        check("R9 edge count", count0, 16'h0005);
        tick = 1'b0;
        pulse_ext(2);
        repeat (4) @(negedge clk);
        check("R9 held without tick", count0, 16'h0005);
        ticks(1);
        check("R9 one step per tick", count0, 16'h0006);
        ticks(3);
        check("R9 no extra steps", count0, 16'h0006);

        // R10 write priority
        wr_cfg(8'h01);
        load(1'b0, 16'h1234);
        @(negedge clk); tick = 1'b1; cnt_we = 1'b1; cnt_ch = 1'b0; cnt_hi = 1'b0; cnt_wdata = 8'h55;
        @(negedge clk); tick = 1'b0; cnt_we = 1'b0;
        check("R10 low write wins", count0, 16'h1255);
        wr_bit(2'd2, 1'b0);
        load(1'b0, 16'hFFFF);
        @(negedge clk); tick = 1'b1; cnt_we = 1'b1; cnt_hi = 1'b1; cnt_wdata = 8'h00;
        @(negedge clk); tick = 1'b0; cnt_we = 1'b0;
        check("R10 high write wins", count0, 16'h00FF);
        check("R10 no flag", ovf[0], 1'b0);

        // R11 acknowledge
        load(1'b0, 16'hFFFF);
        ticks(1);
        check("R11 flag set", {ovf[0], count0}, 17'h10000);
        @(negedge clk); irq_ack[0] = 1'b1;
        @(negedge clk); irq_ack[0] = 1'b0;
        check("R11 ack clears", ovf[0], 1'b0);
        load(1'b0, 16'hFFFF);
        @(negedge clk); tick = 1'b1; irq_ack[0] = 1'b1;
        @(negedge clk); tick = 1'b0; irq_ack[0] = 1'b0;
        check("R11 overflow beats ack", ovf[0], 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule